// File: doc/BRIEF.md
# Debug-Bus Control Port on a PC I/O Bus

This block is a single byte-wide register mapped into the I/O space of a PC-style peripheral bus. Software uses it to drive the control lines of a serial debug bus directly. Each register write sets six lines: reset, freeze, execute, serial data, address phase and shift clock. A register read returns those six lines together with the live level of the debug bus's serial return. To run the debug protocol, software writes the register repeatedly and raises and lowers the shift clock bit on each write.

The bus strobes are active low and are sampled on the block's clock. While the write strobe is low, the block captures the address match and the low six data bits every cycle. When the strobe is seen high again, the last captured value is committed, provided the address matched. The read data bus is driven only while the read strobe is low and the address matches; otherwise it is held at zero. The serial-return input passes through a parameterised synchroniser before it reaches the read data.

Top module: `dbg_ctrl_port`

## Requirements
- R1: After the synchronous reset `rst`, the reset and freeze lines are 1 and the other four debug lines are 0. A read then returns 0x30 when the serial return is low.
- R2: A write to address 0x600F takes effect in the first clock edge at which `bus_wr_n` is sampled high after having been sampled low. Write data bit 5 drives reset, bit 4 freeze, bit 3 execute, bit 2 serial data, bit 1 address phase and bit 0 shift clock. The debug lines do not change while the strobe is still low.
- R3: A write strobe cycle at any address other than 0x600F leaves all six debug lines unchanged.
- R4: The address and data sampled in the last cycle in which `bus_wr_n` was low decide the commit. A change of address or data in the same cycle as the strobe rises has no effect.
- R5: While `bus_rd_n` is low and the address is 0x600F, `bus_rdata` bits 5..0 equal the current debug lines in the write bit positions, and bit 7 equals the synchronised serial return.
- R6: `bus_rdata` is 0 whenever `bus_rd_n` is high or the address is not 0x600F.
- R7: Read data bit 6 is always 0. Write data bits 7 and 6 have no effect on any debug line.
- R8: A change of `dbg_sdo` appears in read data bit 7 after exactly SDO_SYNC (default 2) rising clock edges.
- R9: Asserting `rst` at any time restores the state of R1 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; bus strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data from the host |
| bus_rdata | output | 8 | Read data to the host, zero when not selected |
| bus_wr_n | input | 1 | I/O write strobe, active low |
| bus_rd_n | input | 1 | I/O read strobe, active low |
| dbg_reset | output | 1 | Debug-bus reset line |
| dbg_freeze | output | 1 | Debug-bus freeze line |
| dbg_execute | output | 1 | Debug-bus execute line |
| dbg_sdi | output | 1 | Debug-bus serial data toward the targets |
| dbg_addr_phase | output | 1 | Debug-bus address-phase select |
| dbg_shift_clk | output | 1 | Debug-bus shift clock |
| dbg_sdo | input | 1 | Serial return from the debug bus |

## Verification
The bound checker verifies several rules on every cycle. The debug lines hold when no strobe edge occurs. A strobe release at a foreign address commits nothing. A release after a matching address commits the data captured in the last low cycle. The read bus is zero whenever the block is not selected, and it mirrors the debug lines when it is selected. The bench scenarios cover the rest. They show the synchroniser latency on the serial return, the swap of address or data at the moment of release, the masking of the top write bits, and a reset issued in the middle of traffic, with random writes and reads checked against a bench model.

// File: rtl/dbgport_pkg.sv
package dbgport_pkg;

    localparam int CTRL_W  = 6;
    localparam int SDO_BIT = 7;

    // Field order fixes the bit positions: reset is bit 5, shift clock bit 0.
    typedef struct packed {
        logic reset;
        logic freeze;
        logic execute;
        logic sdi;
        logic addr_phase;
        logic shift_clk;
    } ctrl_t;

    localparam ctrl_t CTRL_POR = '{reset: 1'b1, freeze: 1'b1, default: 1'b0};

    // Write capture held across the low phase of the write strobe.
    typedef struct packed {
        logic  hit;
        ctrl_t data;
    } wcap_t;

endpackage

// File: rtl/dbgport_decode.sv
module dbgport_decode #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h600F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = (addr == PORT_ADDR);
    end
endmodule

// File: rtl/dbgport_sync.sv
module dbgport_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES == 0) begin : g_bypass
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

            always_comb begin
                stg_d[0] = d;
                for (int i = 1; i < STAGES; i++) begin
                    stg_d[i] = stg_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q <= '0;
                end else begin
                    stg_q <= stg_d;
                end
            end

            assign q = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dbgport_wcap.sv
module dbgport_wcap
    import dbgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h600F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit,
    output ctrl_t             data
);
    typedef struct packed {
        logic  strobe;
        wcap_t cap;
    } wstate_t;

    wstate_t st_d, st_q;
    logic    addr_hit;
    logic    unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:CTRL_W];

    dbgport_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_dec (
        .addr (addr),
        .hit  (addr_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.strobe = wr_n;
        if (!wr_n) begin
            st_d.cap.hit  = addr_hit;
            st_d.cap.data = ctrl_t'(wdata[CTRL_W-1:0]);
        end
        // Release edge: strobe high now, low in the previous sample.
        commit = wr_n && !st_q.strobe && st_q.cap.hit;
        data   = st_q.cap.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.strobe   <= 1'b1;
            st_q.cap.hit  <= 1'b0;
            st_q.cap.data <= CTRL_POR;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dbg_ctrl_port.sv
module dbg_ctrl_port
    import dbgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h600F,
    parameter int                SDO_SYNC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    output logic              dbg_reset,
    output logic              dbg_freeze,
    output logic              dbg_execute,
    output logic              dbg_sdi,
    output logic              dbg_addr_phase,
    output logic              dbg_shift_clk,
    input  logic              dbg_sdo
);
    typedef struct packed {
        ctrl_t ctrl;
    } port_state_t;

    port_state_t st_d, st_q;
    logic        wr_commit;
    ctrl_t       wr_data;
    logic        rd_hit;
    logic        sdo_s;

    dbgport_wcap #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_wcap (
        .clk    (clk),
        .rst    (rst),
        .wr_n   (bus_wr_n),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .commit (wr_commit),
        .data   (wr_data)
    );

    dbgport_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_ADDR (PORT_ADDR)
    ) u_rdec (
        .addr (bus_addr),
        .hit  (rd_hit)
    );

    dbgport_sync #(
        .WIDTH  (1),
        .STAGES (SDO_SYNC)
    ) u_sdo_sync (
        .clk (clk),
        .rst (rst),
        .d   (dbg_sdo),
        .q   (sdo_s)
    );

    always_comb begin
        st_d = st_q;
        if (wr_commit) begin
            st_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ctrl <= CTRL_POR;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_rd_n && rd_hit) begin
            bus_rdata[CTRL_W-1:0] = st_q.ctrl;
            bus_rdata[SDO_BIT]    = sdo_s;
        end
    end

    assign dbg_reset      = st_q.ctrl.reset;
    assign dbg_freeze     = st_q.ctrl.freeze;
    assign dbg_execute    = st_q.ctrl.execute;
    assign dbg_sdi        = st_q.ctrl.sdi;
    assign dbg_addr_phase = st_q.ctrl.addr_phase;
    assign dbg_shift_clk  = st_q.ctrl.shift_clk;
endmodule

// File: rtl/dbgport_chk.sv
module dbgport_chk #(
    parameter int                ADDR_W    = 16,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h600F
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              wr_n,
    input logic              rd_n,
    input logic [5:0]        lines
);
    logic [1:0] live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 2'd0;
        end else if (live_q != 2'd2) begin
            live_q <= live_q + 2'd1;
        end
    end

    AST_POR_VALUE: assert property (@(posedge clk)
        rst |=> (lines == 6'h30)); // R1

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (live_q == 2'd2 && wr_n && $past(wr_n)) |=> $stable(lines)); // R2

    AST_MISS_NO_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (live_q == 2'd2 && wr_n && !$past(wr_n) && $past(addr) != PORT_ADDR)
        |=> $stable(lines)); // R3

    AST_HIT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        (live_q == 2'd2 && wr_n && !$past(wr_n) && $past(addr) == PORT_ADDR)
        |=> (lines == $past(wdata[5:0], 2))); // R4

    AST_READ_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && addr == PORT_ADDR) |-> (rdata[5:0] == lines && !rdata[6])); // R5

    AST_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (rd_n || addr != PORT_ADDR) |-> (rdata == '0)); // R6
endmodule

bind dbg_ctrl_port dbgport_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .wr_n  (bus_wr_n),
    .rd_n  (bus_rd_n),
    .lines ({dbg_reset, dbg_freeze, dbg_execute, dbg_sdi, dbg_addr_phase, dbg_shift_clk})
);

// File: tb/sim_dbg_ctrl_port.sv
`timescale 1ns/1ps
module sim_dbg_ctrl_port;
    localparam logic [15:0] PORT = 16'h600F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        bus_wr_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        dbg_reset, dbg_freeze, dbg_execute, dbg_sdi, dbg_addr_phase, dbg_shift_clk;
    logic        dbg_sdo = 1'b0;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [5:0]  ctrl_m = 6'h30;
    logic        sdo_m  = 1'b0;

    always #2.5 clk = ~clk;

    dbg_ctrl_port u0 (
        .clk (clk), .rst (rst), .bus_addr (bus_addr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .bus_wr_n (bus_wr_n), .bus_rd_n (bus_rd_n),
        .dbg_reset (dbg_reset), .dbg_freeze (dbg_freeze), .dbg_execute (dbg_execute),
        .dbg_sdi (dbg_sdi), .dbg_addr_phase (dbg_addr_phase),
        .dbg_shift_clk (dbg_shift_clk), .dbg_sdo (dbg_sdo)
    );

    function automatic logic [7:0] exp_read(input logic [15:0] a, input logic [5:0] c, input logic s);
        return (a == PORT) ? {s, 1'b0, c} : 8'h00;
    endfunction

    function automatic logic [5:0] lines();
        return {dbg_reset, dbg_freeze, dbg_execute, dbg_sdi, dbg_addr_phase, dbg_shift_clk};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                            input bit swap, input logic [15:0] a2);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 lines hold while strobe low", {2'b00, lines()}, {2'b00, ctrl_m});
        bus_wr_n = 1'b1;
        if (swap) begin
            bus_addr = a2; bus_wdata = ~d;
        end
        @(negedge clk);
        if (a == PORT) ctrl_m = d[5:0];
        chk(swap ? "R4 release-cycle swap" : (a == PORT ? "R2 write commit" : "R3 foreign write"),
            {2'b00, lines()}, {2'b00, ctrl_m});
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd_n = 1'b0;
        #1;
        chk(tag, bus_rdata, exp_read(a, ctrl_m, sdo_m));
        bus_rd_n = 1'b1;
        #1;
        chk("R6 idle read bus", bus_rdata, 8'h00);
    endtask

    task automatic set_sdo(input logic v);
        @(negedge clk);
        dbg_sdo = v;
        repeat (2) @(negedge clk);
        sdo_m = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 power-on lines", {2'b00, lines()}, 8'h30);
        do_read(PORT, "R1 power-on read");

        do_write(PORT, 8'h3F, 1'b0, 16'h0);
        do_read(PORT, "R5 read all ones");
        do_write(PORT, 8'h00, 1'b0, 16'h0);
        do_write(PORT, 8'hC5, 1'b0, 16'h0);   // R7 top bits ignored
        do_read(PORT, "R7 upper write bits masked");
        do_write(16'h600E, 8'h2A, 1'b0, 16'h0);
        do_write(16'h700F, 8'h2A, 1'b0, 16'h0);
        do_read(16'h600E, "R6 foreign read");
        do_write(PORT, 8'h12, 1'b1, 16'h1234);  // R4 hit then address moves
        do_write(16'h1234, 8'h3F, 1'b1, PORT);  // R4 miss then address moves onto port

        // R8 serial-return latency
        @(negedge clk);
        bus_addr = PORT; bus_rd_n = 1'b0;
        dbg_sdo = 1'b1;
        @(negedge clk); #1;
        chk("R8 sdo after one edge", bus_rdata, {1'b0, 1'b0, ctrl_m});
        @(negedge clk); #1;
        chk("R8 sdo after two edges", bus_rdata, {1'b1, 1'b0, ctrl_m});
        sdo_m = 1'b1;
        bus_rd_n = 1'b1;

        // Random traffic
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [15:0] ra;
            op = $urandom % 4;
            ra = $urandom;
            if (ra == PORT) ra = 16'h0;
            case (op)
                0: do_write(PORT, 8'($urandom), 1'b0, 16'h0);
                1: do_write(ra, 8'($urandom), 1'b0, 16'h0);
                2: do_read(($urandom % 2) ? PORT : ra, "R5 random read");
                default: set_sdo(1'($urandom));
            endcase
        end

        // R9 reset in the middle of traffic
        do_write(PORT, 8'h0F, 1'b0, 16'h0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ctrl_m = 6'h30;
        sdo_m  = 1'b0;
        chk("R9 mid-run reset lines", {2'b00, lines()}, 8'h30);
        set_sdo(1'b0);
        do_read(PORT, "R9 mid-run reset read");

        repeat (2) @(negedge clk);
        summary();
    end
endmodule